// File: doc/BRIEF.md
# Serial-Programmed Bidirectional Pin Latch

This block drives a small group of general-purpose pins. Each pin can act as an input or an output. A serial control port programs two registers: a direction register and a pin latch register. The control port runs on its own control clock and is framed by an active-low select. Pins marked as outputs drive the value held in the latch register. Pins marked as inputs are not watched all the time. Their levels are taken into the latch register only when a write frame runs, and that same frame shifts the taken sample back to the controller on the serial output.

A frame is one instruction byte followed by one data byte, both sent MSB first. The instruction chooses a read or a write of either register. The controller reads pin states by issuing a write and collecting the returned byte. A synchronous active-high master reset puts every pin back to input and clears both registers. The pad buffers sit outside this block; it only supplies an output value and an output-enable for each pin.

Top module: `serial_latch_port`

## Requirements
- R1: While `mrst` is high at a rising edge of `sclk`, the block resets: `pad_oe` and `pad_out` become all zero, and `sdo` is 0 after the next falling edge.
- R2: A frame carries an instruction byte and then a data byte, both MSB first. Instruction bit 7 selects read (1) or write (0). Instruction bit 0 selects the direction register (0) or the latch register (1). Bits 6..1 are don't-care.
- R3: `sdi` is sampled on the rising edge of `sclk`, and `sdo` changes only on the falling edge. `sdo` carries the returned byte MSB first during the data byte and is 0 during the instruction byte.
- R4: At the end of a write frame to the direction register, the data byte is loaded into that register.
- R5: Every write frame captures the input-pin levels at the rising edge that completes the instruction byte. During the data byte, `sdo` returns the capture: pad levels at input-pin positions and the current latch bits at output-pin positions.
- R6: At the end of every write frame, the latch bits of input pins (under the direction in force before the frame) take the captured levels. In a latch write, the latch bits of output pins take the data byte; in a direction write, they keep their old values.
- R7: `pad_oe[i]` equals direction bit i, where 1 means output. `pad_out` equals the latch register.
- R8: A read frame returns the selected register on `sdo` and changes no register.
- R9: While `cs_n` is high the bit counter restarts. A frame cut short before its sixteenth bit writes nothing, and the next frame decodes normally.
- R10: Bits clocked in after the sixteenth bit of a frame are ignored until `cs_n` goes high.
- R11: The pin count is the parameter NPIN (1..8). Data bits at NPIN and above are ignored on writes and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Control clock |
| mrst | input | 1 | Synchronous active-high master reset |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, updated on falling edges |
| pad_in | input | NPIN | Levels sensed at the pins |
| pad_out | output | NPIN | Values to drive on output pins |
| pad_oe | output | NPIN | Per-pin output enable (1 = output) |

## Verification
The bench checks the returned capture byte when the pins are mixed inputs and outputs. A design that took all pins from the pads, or that captured at the end of the frame, would return the wrong byte. It checks that written data does not reach input-pin latch bits and that pad levels do not overwrite output-pin bits. It checks that a frame cut short leaves both registers unchanged, and that the next frame is still decoded, which catches a counter that is not cleared. It also confirms that extra trailing bits and upper data bits have no effect, and that `sdo` holds steady across rising edges, which exposes an output register clocked on the wrong edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    OP_WR_DIR = 2'b00,
    OP_WR_LAT = 2'b01,
    OP_RD_DIR = 2'b10,
    OP_RD_LAT = 2'b11
  } op_e;

  function automatic op_e decode_op(input logic [BYTE_W-1:0] b);
    return op_e'({b[BYTE_W-1], b[0]});
  endfunction

  function automatic logic op_is_read(input op_e o);
    return o[1];
  endfunction
endpackage

// File: rtl/slp_frame.sv
module slp_frame
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              instr_fire,
  output logic              data_fire,
  output op_e               op_q
);
  logic [BYTE_W-2:0] sh_q;

  assign cur_byte   = {sh_q, sdi};
  assign instr_fire = !cs_n && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign data_fire  = !cs_n && (bit_cnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      op_q    <= OP_RD_DIR;
    end else if (cs_n) begin
      bit_cnt <= '0;
    end else if (bit_cnt != CNT_W'(FRAME_BITS)) begin
      bit_cnt <= bit_cnt + 1'b1;
      sh_q    <= cur_byte[BYTE_W-2:0];
      if (instr_fire) op_q <= decode_op(cur_byte);
    end
  end
endmodule

// File: rtl/slp_regs.sv
module slp_regs
  import slp_pkg::*;
#(
  parameter int NPIN = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_fire,
  input  logic              data_fire,
  input  op_e               op_q,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   lat_q,
  output logic [BYTE_W-1:0] obyte_q
);
  logic [NPIN-1:0]   cap_q, cap_now, lat_next;
  logic [BYTE_W-1:0] obyte_next;
  op_e               op_new;

  assign op_new = decode_op(cur_byte);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign cap_now[i]  = dir_q[i] ? lat_q[i] : pad_in[i];
    assign lat_next[i] = dir_q[i] ? ((op_q == OP_WR_LAT) ? cur_byte[i] : lat_q[i])
                                  : cap_q[i];
  end

  always_comb begin
    unique case (op_new)
      OP_RD_DIR: obyte_next = BYTE_W'(dir_q);
      OP_RD_LAT: obyte_next = BYTE_W'(lat_q);
      default:   obyte_next = BYTE_W'(cap_now);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      lat_q   <= '0;
      cap_q   <= '0;
      obyte_q <= '0;
    end else begin
      if (instr_fire) begin
        obyte_q <= obyte_next;
        if (!op_is_read(op_new)) cap_q <= cap_now;
      end
      if (data_fire && !op_is_read(op_q)) begin
        lat_q <= lat_next;
        if (op_q == OP_WR_DIR) dir_q <= cur_byte[NPIN-1:0];
      end
    end
  end
endmodule

// File: rtl/slp_sdo.sv
module slp_sdo
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] obyte,
  output logic              sdo
);
  logic           in_data;
  logic [IDX_W-1:0] idx;

  assign in_data = !cs_n && (bit_cnt >= CNT_W'(BYTE_W)) && (bit_cnt < CNT_W'(FRAME_BITS));
  assign idx     = IDX_W'(FRAME_BITS - 1 - int'(bit_cnt));

  always_ff @(negedge clk) begin
    if (rst)          sdo <= 1'b0;
    else if (in_data) sdo <= obyte[idx];
    else              sdo <= 1'b0;
  end
endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port
  import slp_pkg::*;
#(
  parameter int NPIN = 6
)(
  input  logic            sclk,
  input  logic            mrst,
  input  logic            cs_n,
  input  logic            sdi,
  output logic            sdo,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] cur_byte, obyte;
  logic              instr_fire, data_fire;
  op_e               op_q;
  logic [NPIN-1:0]   dir_q, lat_q;

  slp_frame u_frame (
    .clk(sclk), .rst(mrst), .cs_n(cs_n), .sdi(sdi),
    .bit_cnt(bit_cnt), .cur_byte(cur_byte),
    .instr_fire(instr_fire), .data_fire(data_fire), .op_q(op_q)
  );

  slp_regs #(.NPIN(NPIN)) u_regs (
    .clk(sclk), .rst(mrst), .instr_fire(instr_fire), .data_fire(data_fire),
    .op_q(op_q), .cur_byte(cur_byte), .pad_in(pad_in),
    .dir_q(dir_q), .lat_q(lat_q), .obyte_q(obyte)
  );

  slp_sdo u_sdo (
    .clk(sclk), .rst(mrst), .cs_n(cs_n), .bit_cnt(bit_cnt),
    .obyte(obyte), .sdo(sdo)
  );

  assign pad_oe  = dir_q;
  assign pad_out = lat_q;
endmodule

// File: rtl/slp_chk.sv
module slp_chk
  import slp_pkg::*;
#(
  parameter int NPIN = 6
)(
  input logic             sclk,
  input logic             mrst,
  input logic             cs_n,
  input logic             sdo,
  input logic [NPIN-1:0]  pad_out,
  input logic [NPIN-1:0]  pad_oe,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             data_fire,
  input logic [1:0]       op_bits
);
  // R1
  reset_clear_chk: assert property (@(posedge sclk)
    mrst |=> (pad_oe == '0 && pad_out == '0));

  // R9
  cnt_restart_chk: assert property (@(posedge sclk) disable iff (mrst)
    cs_n |=> (bit_cnt == '0));

  // R10
  tail_ignored_chk: assert property (@(posedge sclk) disable iff (mrst)
    (!cs_n && bit_cnt == CNT_W'(FRAME_BITS)) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R8
  read_no_write_chk: assert property (@(posedge sclk) disable iff (mrst)
    (data_fire && op_bits[1]) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R4
  dir_only_at_end_chk: assert property (@(posedge sclk) disable iff (mrst)
    !data_fire |=> $stable(pad_oe));

  // R3
  sdo_quiet_chk: assert property (@(posedge sclk) disable iff (mrst)
    (!cs_n && bit_cnt < CNT_W'(BYTE_W)) |-> !sdo);
endmodule

bind serial_latch_port slp_chk #(.NPIN(NPIN)) u_chk (
  .sclk(sclk), .mrst(mrst), .cs_n(cs_n), .sdo(sdo),
  .pad_out(pad_out), .pad_oe(pad_oe), .bit_cnt(bit_cnt),
  .data_fire(data_fire), .op_bits(op_q)
);

// File: tb/serial_latch_port_test.sv
module serial_latch_port_test;
  localparam int NPIN = 6;

  logic            clk = 1'b0;
  logic            mrst = 1'b1;
  logic            cs_n = 1'b1;
  logic            sdi = 1'b0;
  logic [NPIN-1:0] pad_in = '0;
  logic            sdo;
  logic [NPIN-1:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  logic [NPIN-1:0] m_dir = '0;
  logic [NPIN-1:0] m_lat = '0;
  logic            idle_bad, edge_bad;

  serial_latch_port #(.NPIN(NPIN)) uut (
    .sclk(clk), .mrst(mrst), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive nbits of a frame; returns the data-phase byte seen on sdo.
  task automatic xfer(input logic [7:0] ins, input logic [7:0] dat, input int nbits,
                      output logic [7:0] rx);
    logic s;
    rx = '0; idle_bad = 1'b0; edge_bad = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); #2;
      s = sdo;
      if (i > 0 && i < 8 && s !== 1'b0) idle_bad = 1'b1;
      if (i >= 8 && i < 16) rx = {rx[6:0], s};
      cs_n = 1'b0;
      sdi  = (i < 8) ? ins[7-i] : (i < 16) ? dat[15-i] : 1'b1;
      @(posedge clk); #1;
      if (i >= 8 && i < 16 && sdo !== s) edge_bad = 1'b1;
    end
    @(negedge clk); #2;
    if (nbits >= 16 && nbits < 17) rx = {rx[6:0], 1'b0} >> 1 | rx; // keep rx as collected
    cs_n = 1'b1; sdi = 1'b0;
    @(negedge clk); #2;
  endtask

  // Model of a full write frame; returns the expected capture byte.
  task automatic model_write(input logic [7:0] ins, input logic [7:0] dat,
                             output logic [7:0] exp_rx);
    logic [NPIN-1:0] cap;
    for (int i = 0; i < NPIN; i++) cap[i] = m_dir[i] ? m_lat[i] : pad_in[i];
    exp_rx = 8'(cap);
    for (int i = 0; i < NPIN; i++)
      m_lat[i] = m_dir[i] ? (ins[0] ? dat[i] : m_lat[i]) : cap[i];
    if (!ins[0]) m_dir = dat[NPIN-1:0];
  endtask

  task automatic do_write(input string req, input logic [7:0] ins, input logic [7:0] dat);
    logic [7:0] rx, exp_rx;
    model_write(ins, dat, exp_rx);
    xfer(ins, dat, 16, rx);
    chk({req, " R5 capture byte"}, rx, exp_rx);
    chk({req, " R4 pad_oe"}, 8'(pad_oe), 8'(m_dir));
    chk({req, " R6 pad_out"}, 8'(pad_out), 8'(m_lat));
    chk("R3 sdo idle in instruction byte", {7'd0, idle_bad}, 8'd0);
    chk("R3 sdo steady at rising edge", {7'd0, edge_bad}, 8'd0);
  endtask

  task automatic do_read(input string req, input logic [7:0] ins);
    logic [7:0] rx;
    logic [NPIN-1:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    xfer(ins, 8'hFF, 16, rx);
    chk({req, " R8 read value"}, rx, ins[0] ? 8'(m_lat) : 8'(m_dir));
    chk({req, " R8 pad_oe unchanged"}, 8'(pad_oe), 8'(oe0));
    chk({req, " R8 pad_out unchanged"}, 8'(pad_out), 8'(out0));
  endtask

  task automatic t_reset();
    mrst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    mrst = 1'b0;
    m_dir = '0; m_lat = '0;
    chk("R1 pad_oe after reset", 8'(pad_oe), 8'd0);
    chk("R1 pad_out after reset", 8'(pad_out), 8'd0);
    chk("R1 sdo after reset", {7'd0, sdo}, 8'd0);
  endtask

  task automatic t_dir_write();
    pad_in = 6'h15;
    do_write("R2 dir write with don't-care bits", 8'h7E, 8'h2A);
    chk("R7 pad_oe follows direction", 8'(pad_oe), 8'h2A);
  endtask

  task automatic t_latch_mixed();
    pad_in = 6'h3F;
    do_write("R6 latch write zeros", 8'h01, 8'h00);
    pad_in = 6'h00;
    do_write("R6 latch write ones", 8'h01, 8'h3F);
    chk("R6 input bits ignore data", 8'(pad_out), 8'h2A);
  endtask

  task automatic t_reads();
    pad_in = 6'h3F;
    do_read("R8 dir", 8'h80);
    do_read("R8 latch", 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    logic [NPIN-1:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    xfer(8'h01, 8'h00, 12, rx);
    chk("R9 aborted frame pad_oe", 8'(pad_oe), 8'(oe0));
    chk("R9 aborted frame pad_out", 8'(pad_out), 8'(out0));
    pad_in = 6'h00;
    do_write("R9 frame after abort", 8'h01, 8'h02);
  endtask

  task automatic t_tail();
    logic [7:0] rx, exp_rx;
    pad_in = 6'h21;
    model_write(8'h00, 8'h0F, exp_rx);
    xfer(8'h00, 8'h0F, 24, rx);
    chk("R10 trailing bits ignored pad_oe", 8'(pad_oe), 8'h0F);
    chk("R10 trailing bits ignored pad_out", 8'(pad_out), 8'(m_lat));
    chk("R10 capture byte", rx, exp_rx);
  endtask

  task automatic t_width();
    pad_in = 6'h00;
    do_write("R11 upper bits", 8'h00, 8'hFF);
    chk("R11 pad_oe width", 8'(pad_oe), 8'h3F);
    do_read("R11 dir readback", 8'h80);
  endtask

  task automatic t_mrst_pulse();
    @(negedge clk); #2;
    mrst = 1'b1;
    @(negedge clk); #2;
    mrst = 1'b0;
    m_dir = '0; m_lat = '0;
    chk("R1 pulse clears pad_oe", 8'(pad_oe), 8'd0);
    chk("R1 pulse clears pad_out", 8'(pad_out), 8'd0);
    pad_in = 6'h2D;
    do_write("R1 all inputs after pulse", 8'h01, 8'h3F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_dir_write();
    t_latch_mixed();
    t_reads();
    t_abort();
    t_tail();
    t_width();
    t_mrst_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule